// File: doc/BRIEF.md
# Bit Test and Modify Unit

This execution unit performs a single-bit test on a 32-bit operand and, if asked, modifies that bit. There are four operations: test only, test-and-set, test-and-clear and test-and-toggle. Every operation returns the value the selected bit had before the change, as a carry flag. The operand is either a register value supplied on the request or a dword in memory that the unit fetches through a simple request/ready port.

The bit offset comes from a 32-bit register or from an 8-bit immediate. The low five bits pick the bit inside the dword. With a register offset and a memory target, the remaining upper bits of the offset act as a signed dword displacement. This lets one request reach bits far above or below the effective address. An immediate offset always stays inside the dword at the effective address. Before the access, the final address is cut to 16 or 32 bits as the address-size input selects.

A register target finishes one cycle after the start and returns the updated word for write-back. A memory target runs a short sequence: a read, then a write of the updated dword for modifying operations, then completion. Results appear only on the completion cycle.

Top module: `bitop_unit`

## Requirements
- R1: `op` selects 0 = test, 1 = set (bit forced to 1), 2 = clear (bit forced to 0), 3 = toggle (bit inverted). `cf` always returns the bit's value before any change.
- R2: The bit index is bits [4:0] of the offset, taken from `off_reg` when `use_imm`=0 and from `off_imm` when `use_imm`=1. Higher immediate bits are ignored.
- R3: For a register target (`tgt_mem`=0), `done` rises exactly one cycle after `start` is sampled. In that cycle `wb_en`=1 with the updated word on `wb_data` for ops 1..3, and `wb_en`=0 for test. `wb_en` is never high outside a `done` cycle or for memory targets.
- R4: For a memory target with a register offset, the access address is `eff_addr` + 4 × (`off_reg` arithmetically shifted right by 5), modulo 2^32, then masked.
- R5: For a memory target with an immediate offset, the access address is `eff_addr` masked, with no displacement.
- R6: With `addr32`=0 the access address keeps only its low 16 bits (upper bits zero). With `addr32`=1 all 32 bits are kept.
- R7: A memory test issues exactly one read (`mem_we`=0) and no write.
- R8: A memory set, clear or toggle issues one read, then one write (`mem_we`=1) to the same address, carrying the read dword with the selected bit updated.
- R9: A memory request holds `mem_req`, `mem_addr`, `mem_we` and `mem_wdata` unchanged until `mem_rdy` is sampled high.
- R10: `done` is a single-cycle pulse, once per accepted request. `cf` changes only in a `done` cycle. A `start` while `busy` is ignored.
- R11: After reset, `done`, `cf`, `wb_en`, `mem_req`, `mem_we` and `busy` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Request strobe, sampled while idle |
| op | input | 2 | Operation: 0 test, 1 set, 2 clear, 3 toggle |
| tgt_mem | input | 1 | 1 = memory dword target, 0 = register target |
| use_imm | input | 1 | 1 = offset from `off_imm`, 0 = from `off_reg` |
| reg_val | input | 32 | Register target value |
| off_reg | input | 32 | Register bit offset (signed) |
| off_imm | input | 8 | Immediate bit offset |
| eff_addr | input | 32 | Effective address of the memory operand |
| addr32 | input | 1 | 1 = 32-bit addresses, 0 = 16-bit |
| mem_req | output | 1 | Memory request valid |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Request address |
| mem_wdata | output | 32 | Write data |
| mem_rdata | input | 32 | Read data, valid with `mem_rdy` on a read |
| mem_rdy | input | 1 | Memory accepts/completes the request |
| busy | output | 1 | Memory sequence in progress |
| done | output | 1 | One-cycle completion pulse |
| cf | output | 1 | Original value of the selected bit |
| wb_en | output | 1 | Register write-back enable |
| wb_data | output | 32 | Register write-back value |

## Verification
Random requests mix all four operations, both target kinds, both offset sources and both address sizes. Offsets span the full 32-bit range, so the negative, zero and large positive displacements all occur. Directed cases cover index 0 and index 31, which expose a swapped or off-by-one bit select. A negative register offset tells an arithmetic shift apart from a logical one. An immediate with its upper bits set shows that only five bits are used. A sum that overflows 16 bits shows where the mask is applied. Random ready delays stress request holding, and a start pulse driven during a stalled access must leave the running operation and its result untouched.

// File: rtl/bitop_pkg.sv
package bitop_pkg;
  typedef enum logic [1:0] {OP_TEST = 2'd0, OP_SET = 2'd1, OP_CLR = 2'd2, OP_FLIP = 2'd3} bitop_e;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_RD = 2'd1, ST_WR = 2'd2} bitop_st_e;
endpackage

// File: rtl/bitop_addr.sv
module bitop_addr #(
  parameter int DW     = 32,
  parameter int AW     = 32,
  parameter int NARROW = 16
) (
  input  logic          use_imm,
  input  logic [DW-1:0] off_reg,
  input  logic [AW-1:0] eff_addr,
  input  logic          addr32,
  output logic [AW-1:0] addr
);
  localparam int IW = $clog2(DW);
  localparam int SH = $clog2(DW / 8);

  logic signed [DW-1:0] soff;
  logic [AW-1:0]        step;
  logic [AW-1:0]        raw;
  logic [AW-1:0]        mask;

  assign soff = $signed(off_reg);
  assign step = AW'(soff >>> IW) << SH;
  assign raw  = use_imm ? eff_addr : eff_addr + step;

  generate
    if (AW > NARROW) begin : g_mask
      assign mask = addr32 ? {AW{1'b1}} : {{(AW-NARROW){1'b0}}, {NARROW{1'b1}}};
    end else begin : g_nomask
      assign mask = {AW{1'b1}};
    end
  endgenerate

  assign addr = raw & mask;
endmodule

// File: rtl/bitop_alu.sv
module bitop_alu
  import bitop_pkg::*;
#(
  parameter int DW = 32,
  localparam int IW = $clog2(DW)
) (
  input  bitop_e        op,
  input  logic [DW-1:0] word,
  input  logic [IW-1:0] idx,
  output logic          orig,
  output logic [DW-1:0] result,
  output logic          modifies
);
  logic [DW-1:0] sel;

  assign sel      = DW'(1) << idx;
  assign orig     = word[idx];
  assign modifies = (op != OP_TEST);

  always_comb begin
    case (op)
      OP_SET:  result = word | sel;
      OP_CLR:  result = word & ~sel;
      OP_FLIP: result = word ^ sel;
      default: result = word;
    endcase
  end
endmodule

// File: rtl/bitop_unit.sv
module bitop_unit
  import bitop_pkg::*;
#(
  parameter int DW   = 32,
  parameter int AW   = 32,
  parameter int IMMW = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [1:0]      op,
  input  logic            tgt_mem,
  input  logic            use_imm,
  input  logic [DW-1:0]   reg_val,
  input  logic [DW-1:0]   off_reg,
  input  logic [IMMW-1:0] off_imm,
  input  logic [AW-1:0]   eff_addr,
  input  logic            addr32,
  output logic            mem_req,
  output logic            mem_we,
  output logic [AW-1:0]   mem_addr,
  output logic [DW-1:0]   mem_wdata,
  input  logic [DW-1:0]   mem_rdata,
  input  logic            mem_rdy,
  output logic            busy,
  output logic            done,
  output logic            cf,
  output logic            wb_en,
  output logic [DW-1:0]   wb_data
);
  localparam int IW = $clog2(DW);

  bitop_st_e     state;
  bitop_e        op_q;
  logic [IW-1:0] idx_q;
  logic          cf_hold;

  logic [IW-1:0] idx_now;
  logic [AW-1:0] addr_calc;
  bitop_e        alu_op;
  logic [DW-1:0] alu_word;
  logic [IW-1:0] alu_idx;
  logic          alu_orig;
  logic [DW-1:0] alu_res;
  logic          alu_mod;
  logic          idle;

  assign idle     = (state == ST_IDLE);
  assign idx_now  = use_imm ? off_imm[IW-1:0] : off_reg[IW-1:0];
  assign alu_op   = idle ? bitop_e'(op) : op_q;
  assign alu_word = idle ? reg_val : mem_rdata;
  assign alu_idx  = idle ? idx_now : idx_q;
  assign busy     = !idle;

  bitop_addr #(.DW(DW), .AW(AW)) u_addr (
    .use_imm  (use_imm),
    .off_reg  (off_reg),
    .eff_addr (eff_addr),
    .addr32   (addr32),
    .addr     (addr_calc)
  );

  bitop_alu #(.DW(DW)) u_alu (
    .op       (alu_op),
    .word     (alu_word),
    .idx      (alu_idx),
    .orig     (alu_orig),
    .result   (alu_res),
    .modifies (alu_mod)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      op_q      <= OP_TEST;
      idx_q     <= '0;
      cf_hold   <= 1'b0;
      mem_req   <= 1'b0;
      mem_we    <= 1'b0;
      mem_addr  <= '0;
      mem_wdata <= '0;
      done      <= 1'b0;
      cf        <= 1'b0;
      wb_en     <= 1'b0;
      wb_data   <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            if (tgt_mem) begin
              op_q     <= bitop_e'(op);
              idx_q    <= idx_now;
              mem_req  <= 1'b1;
              mem_we   <= 1'b0;
              mem_addr <= addr_calc;
              state    <= ST_RD;
            end else begin
              done    <= 1'b1;
              cf      <= alu_orig;
              wb_en   <= alu_mod;
              wb_data <= alu_res;
            end
          end
        end
        ST_RD: begin
          if (mem_rdy) begin
            cf_hold <= alu_orig;
            if (alu_mod) begin
              mem_we    <= 1'b1;
              mem_wdata <= alu_res;
              state     <= ST_WR;
            end else begin
              mem_req <= 1'b0;
              done    <= 1'b1;
              cf      <= alu_orig;
              state   <= ST_IDLE;
            end
          end
        end
        ST_WR: begin
          if (mem_rdy) begin
            mem_req <= 1'b0;
            mem_we  <= 1'b0;
            done    <= 1'b1;
            cf      <= cf_hold;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/bitop_chk.sv
module bitop_chk #(
  parameter int DW = 32,
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          mem_req,
  input logic          mem_we,
  input logic [AW-1:0] mem_addr,
  input logic [DW-1:0] mem_wdata,
  input logic          mem_rdy,
  input logic          busy,
  input logic          done,
  input logic          cf,
  input logic          wb_en
);
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    mem_req && !mem_rdy |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R9
  AST_BUSY_HAS_REQ: assert property (@(posedge clk) disable iff (rst)
    busy |-> mem_req); // R9
  AST_CF_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(cf)); // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !mem_req && !busy); // R10
  AST_WB_IN_DONE: assert property (@(posedge clk) disable iff (rst)
    wb_en |-> done); // R3
  AST_WR_AFTER_RD: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we) |-> $past(mem_req && !mem_we && mem_rdy) && $stable(mem_addr)); // R8
endmodule

bind bitop_unit bitop_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_wdata (mem_wdata),
  .mem_rdy   (mem_rdy),
  .busy      (busy),
  .done      (done),
  .cf        (cf),
  .wb_en     (wb_en)
);

// File: tb/test_bitop_unit.sv
module test_bitop_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [1:0]  op = 2'd0;
  logic        tgt_mem = 1'b0;
  logic        use_imm = 1'b0;
  logic [31:0] reg_val = '0;
  logic [31:0] off_reg = '0;
  logic [7:0]  off_imm = '0;
  logic [31:0] eff_addr = '0;
  logic        addr32 = 1'b1;
  logic        mem_req, mem_we, busy, done, cf, wb_en;
  logic [31:0] mem_addr, mem_wdata, wb_data;
  logic [31:0] mem_rdata = '0;
  logic        mem_rdy = 1'b0;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  bitop_unit i_bitop_unit (
    .clk(clk), .rst(rst), .start(start), .op(op), .tgt_mem(tgt_mem),
    .use_imm(use_imm), .reg_val(reg_val), .off_reg(off_reg), .off_imm(off_imm),
    .eff_addr(eff_addr), .addr32(addr32), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_rdy(mem_rdy), .busy(busy), .done(done), .cf(cf), .wb_en(wb_en),
    .wb_data(wb_data)
  );

  function automatic logic [31:0] exp_mod(input logic [1:0] o, input logic [31:0] v, input logic [4:0] ix);
    logic [31:0] b;
    b = 32'd1 << ix;
    case (o)
      2'd1: return v | b;
      2'd2: return v & ~b;
      2'd3: return v ^ b;
      default: return v;
    endcase
  endfunction

  function automatic logic [31:0] exp_addr(input logic im, input logic [31:0] offr, input logic [31:0] eff, input logic a32);
    logic [31:0] a;
    logic [31:0] disp;
    disp = {{5{offr[31]}}, offr[31:5]};
    a = im ? eff : eff + (disp << 2);
    return a32 ? a : {16'h0, a[15:0]};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic [1:0] o, input logic m, input logic im, input logic [31:0] rv,
                        input logic [31:0] offr, input logic [7:0] offi, input logic [31:0] eff,
                        input logic a32, input logic [31:0] mv, input logic poke);
    int cyc, dones, nacc, wait_n, extra;
    logic [31:0] raddr, waddr, wdata, first_addr, v, ea;
    logic [4:0] ix;
    logic got_cf, got_wb, saw_w, hold_ok;
    logic [31:0] got_wbd;
    raddr = '0; waddr = '0; wdata = '0; first_addr = '0; got_cf = 1'b0; got_wb = 1'b0;
    got_wbd = '0; saw_w = 1'b0; hold_ok = 1'b1;
    @(negedge clk);
    op = o; tgt_mem = m; use_imm = im; reg_val = rv; off_reg = offr; off_imm = offi;
    eff_addr = eff; addr32 = a32; start = 1'b1;
    cyc = 0; dones = 0; nacc = 0; wait_n = -1;
    while (dones == 0 && cyc < 60) begin
      @(negedge clk);
      cyc++;
      start = 1'b0;
      mem_rdy = 1'b0;
      if (poke && cyc == 2) begin
        start = 1'b1; op = ~o; tgt_mem = 1'b0; reg_val = ~rv; off_reg = ~offr;
      end
      if (done) begin
        dones++; got_cf = cf; got_wb = wb_en; got_wbd = wb_data;
      end else if (mem_req) begin
        if (wait_n < 0) begin
          wait_n = poke ? 3 : int'($urandom_range(0, 3));
          first_addr = mem_addr;
        end
        if (wait_n == 0) begin
          if (mem_addr !== first_addr) hold_ok = 1'b0;
          mem_rdy = 1'b1;
          mem_rdata = mv;
          if (mem_we) begin saw_w = 1'b1; waddr = mem_addr; wdata = mem_wdata; end
          else raddr = mem_addr;
          nacc++;
          wait_n = -1;
        end else begin
          wait_n--;
        end
      end
    end
    extra = 0;
    repeat (2) begin
      @(negedge clk);
      start = 1'b0;
      mem_rdy = 1'b0;
      if (done) extra++;
    end
    v  = m ? mv : rv;
    ix = im ? offi[4:0] : offr[4:0];
    chk("R1 R2 carry is original bit", {31'd0, got_cf}, {31'd0, v[ix]});
    chk("R10 single done pulse", dones + extra, 1);
    if (!m) begin
      chk("R3 register done latency", cyc, 1);
      chk("R3 write-back enable", {31'd0, got_wb}, {31'd0, (o != 2'd0)});
      if (o != 2'd0) chk("R1 R2 write-back value", got_wbd, exp_mod(o, v, ix));
    end else begin
      ea = exp_addr(im, offr, eff, a32);
      chk("R3 no write-back for memory", {31'd0, got_wb}, 32'd0);
      chk(o == 2'd0 ? "R7 access count" : "R8 access count", nacc, (o == 2'd0) ? 1 : 2);
      chk(!a32 ? "R6 masked address" : (im ? "R5 immediate address" : "R4 displaced address"), raddr, ea);
      chk("R9 request held until ready", {31'd0, hold_ok}, 32'd1);
      if (o != 2'd0) begin
        chk("R8 write address", waddr, ea);
        chk("R8 write data", wdata, exp_mod(o, v, ix));
      end else begin
        chk("R7 no write", {31'd0, saw_w}, 32'd0);
      end
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog timeout");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd7731);
    repeat (4) @(negedge clk);
    chk("R11 reset done", {31'd0, done}, 32'd0);
    chk("R11 reset cf", {31'd0, cf}, 32'd0);
    chk("R11 reset wb_en", {31'd0, wb_en}, 32'd0);
    chk("R11 reset mem_req", {30'd0, mem_req, mem_we}, 32'd0);
    chk("R11 reset busy", {31'd0, busy}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    // directed corner cases
    run_op(2'd0, 1'b0, 1'b0, 32'h0000_0001, 32'h0000_0000, 8'h00, 32'h0, 1'b1, 32'h0, 1'b0);
    run_op(2'd1, 1'b0, 1'b0, 32'h0000_0000, 32'h0000_001F, 8'h00, 32'h0, 1'b1, 32'h0, 1'b0);
    run_op(2'd2, 1'b0, 1'b1, 32'hFFFF_FFFF, 32'h0, 8'hE0, 32'h0, 1'b1, 32'h0, 1'b0);
    run_op(2'd3, 1'b0, 1'b1, 32'h8000_0000, 32'h0, 8'hFF, 32'h0, 1'b1, 32'h0, 1'b0);
    run_op(2'd1, 1'b1, 1'b0, 32'h0, 32'hFFFF_FFC5, 8'h00, 32'h0000_1000, 1'b1, 32'h0000_0000, 1'b0);
    run_op(2'd0, 1'b1, 1'b1, 32'h0, 32'h7FFF_FFE0, 8'hE7, 32'h0000_2000, 1'b1, 32'h0000_0080, 1'b0);
    run_op(2'd2, 1'b1, 1'b0, 32'h0, 32'h0000_0040, 8'h00, 32'h0001_FFFC, 1'b0, 32'hFFFF_FFFF, 1'b0);
    run_op(2'd3, 1'b1, 1'b0, 32'h0, 32'h8000_001F, 8'h00, 32'h1234_5678, 1'b1, 32'h8000_0000, 1'b1);
    run_op(2'd0, 1'b1, 1'b1, 32'h0, 32'h0, 8'h03, 32'hABCD_0010, 1'b0, 32'h0000_0008, 1'b1);
    // random mix
    for (int k = 0; k < 300; k++) begin
      run_op(2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
             $urandom, $urandom, 8'($urandom), $urandom, 1'($urandom_range(0, 1)), $urandom,
             ($urandom_range(0, 9) == 0));
    end
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule